// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 36-bit virtual page number into a 40-bit physical page number. It reads one 64-bit table entry from memory per level, walking four levels from a root table. The root table's frame number comes from a plain control input. At every level the walker checks the entry. A missing entry ends the walk with a not-present fault. An entry that forbids the requested write or user access ends it with a protection fault. If the entry passes its checks but its referenced bit is still clear, the walker writes the entry back with that bit set and then continues. When the last level passes, the block reports its frame number. The full physical address is that frame number with the untouched 12-bit page offset appended below it.

The block handles one walk at a time. There are three streams. Requests arrive on a valid/ready channel. Entry reads and referenced-bit writes leave on a valid/ready memory request channel, and read data comes back on a response channel that has only a valid signal. Results leave on a valid/ready channel carrying the frame number, a fault code and the level at which the walk stopped.

Back-pressure rules:
- A requester holds its request until it sees `req_ready`.
- The walker holds every memory request, unchanged, until `mem_req_ready`.
- At most one read is outstanding, and the walker takes its response in any cycle. Writes get no response.
- The walker holds a result, unchanged, until `res_ready`.

Entry layout:
- bit 0: present
- bit 1: writes allowed
- bit 2: user access allowed
- bit 5: referenced
- bits 51:12: frame number of the next table, or of the page at the last level

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high exactly when no walk is in progress and no result is waiting. A request is taken only on `req_valid && req_ready`, and the walker then issues a read in the next cycle.
- R2: The walker issues the level reads in order, from level 0 to level 3. Each read address is the table frame number shifted left by 12 plus eight times that level's 9-bit index. Level 0 uses the root frame number and VPN bits 35:27, and level 3 uses VPN bits 8:0. Each later level uses the frame number from the entry before it.
- R3: If an entry's present bit (bit 0) is 0, the walk ends at once. The result has fault code 1 and the level of that entry, and no write or further read follows.
- R4: If a write request meets an entry whose bit 1 is 0 at any level, the walk ends with fault code 2 at that level. A read request ignores bit 1.
- R5: If a user request meets an entry whose bit 2 is 0, the walk ends with fault code 2 at that level. When an entry is both absent and forbidden, fault code 1 is reported.
- R6: If an entry passes its checks and its bit 5 is 0, the walker writes the same entry back to the same address with bit 5 set, before the next read or the result. If bit 5 is already 1, no write is issued.
- R7: When the level-3 entry passes, the result has fault code 0, level 3, and `res_ppn` equal to bits 51:12 of that entry. Every faulting result carries `res_ppn` = 0.
- R8: While `res_valid` is high and `res_ready` is low, the result fields stay unchanged.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted with its address, direction and data unchanged.
- R10: After reset the walker is idle: `req_ready` is 1, and `res_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 40 | Frame number of the level-0 table, sampled when a request is taken |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker can take a request |
| req_vpn | input | 36 | Virtual page number to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| mem_req_valid | output | 1 | Entry read or write request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for a referenced-bit write-back |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry to write (zero for reads) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_ppn | output | 40 | Translated frame number (0 on a fault) |
| res_fault | output | 2 | 0 none, 1 not present, 2 permission |
| res_level | output | 2 | Level where the walk stopped |

## Verification
Four rules are checked in every cycle:
- A held memory request or result does not change.
- Every write-back carries bit 5 set.
- A successful result reports level 3.
- Taking a request leads straight to a read.

The bench's scenarios are the only place where the rest is shown. These are: the exact address sequence, whether a write-back happens, the fault code and level for each kind of failing entry, and the absent-over-forbidden priority. The bench shows them by replaying each walk against its own copy of the tables, with memory stalls and a held result.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int PTE_P_BIT = 0;
  localparam int PTE_W_BIT = 1;
  localparam int PTE_U_BIT = 2;
  localparam int PTE_A_BIT = 5;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PERM   = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_CHK,
    ST_WB,
    ST_RES
  } walk_st_e;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 40,
  parameter int OFF_W  = 12,
  parameter int ENT_W  = 64,
  localparam int VPN_W  = LEVELS * IDX_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int ENT_SH = $clog2(ENT_W / 8)
) (
  input  logic [PPN_W-1:0] tbl_base,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  ent_addr
);
  logic [IDX_W-1:0] idx_by_lvl [LEVELS];
  logic [IDX_W-1:0] idx_sel;
  logic [PA_W-1:0]  byte_off;

  // Level 0 takes the most significant slice of the page number.
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx_by_lvl[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign idx_sel = idx_by_lvl[lvl];

  always_comb begin
    byte_off = '0;
    byte_off[ENT_SH +: IDX_W] = idx_sel;
  end

  assign ent_addr = {tbl_base, {OFF_W{1'b0}}} + byte_off;
endmodule

// File: rtl/pgwalk_check.sv
module pgwalk_check
  import pgwalk_pkg::*;
#(
  parameter int PPN_W = 40,
  parameter int OFF_W = 12,
  parameter int ENT_W = 64
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_user,
  output fault_e           verdict,
  output logic             a_clear,
  output logic [PPN_W-1:0] child_base,
  output logic [ENT_W-1:0] entry_marked
);
  logic unused_bits;
  assign unused_bits = ^{entry[ENT_W-1:PPN_W+OFF_W], entry[OFF_W-1:PTE_A_BIT+1],
                         entry[PTE_A_BIT-1:PTE_U_BIT+1]};

  // An absent entry outranks any permission mismatch.
  always_comb begin
    if (!entry[PTE_P_BIT])
      verdict = FLT_ABSENT;
    else if ((is_write && !entry[PTE_W_BIT]) || (is_user && !entry[PTE_U_BIT]))
      verdict = FLT_PERM;
    else
      verdict = FLT_NONE;
  end

  assign a_clear      = !entry[PTE_A_BIT];
  assign child_base   = entry[OFF_W +: PPN_W];
  assign entry_marked = entry | (ENT_W'(1) << PTE_A_BIT);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 40,
  parameter int OFF_W  = 12,
  parameter int ENT_W  = 64,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PPN_W-1:0] root_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  input  logic             req_user,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [ENT_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [PPN_W-1:0] res_ppn,
  output logic [1:0]       res_fault,
  output logic [LVL_W-1:0] res_level
);
  walk_st_e         state;
  logic [LVL_W-1:0] lvl;
  logic [VPN_W-1:0] vpn_q;
  logic             wr_q, usr_q;
  logic [PPN_W-1:0] base_q;
  logic [ENT_W-1:0] ent_q;
  logic [PPN_W-1:0] res_ppn_q;
  fault_e           res_fault_q;
  logic [LVL_W-1:0] res_lvl_q;

  logic [PA_W-1:0]  ent_addr;
  fault_e           verdict;
  logic             a_clear;
  logic [PPN_W-1:0] child_base;
  logic [ENT_W-1:0] entry_marked;
  logic             last_lvl;

  pgwalk_addr #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
  ) u_addr (
    .tbl_base(base_q),
    .vpn     (vpn_q),
    .lvl     (lvl),
    .ent_addr(ent_addr)
  );

  pgwalk_check #(
    .PPN_W(PPN_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
  ) u_check (
    .entry       (ent_q),
    .is_write    (wr_q),
    .is_user     (usr_q),
    .verdict     (verdict),
    .a_clear     (a_clear),
    .child_base  (child_base),
    .entry_marked(entry_marked)
  );

  assign last_lvl = (lvl == LVL_W'(LEVELS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      lvl         <= '0;
      vpn_q       <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      base_q      <= '0;
      ent_q       <= '0;
      res_ppn_q   <= '0;
      res_fault_q <= FLT_NONE;
      res_lvl_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q  <= req_vpn;
            wr_q   <= req_write;
            usr_q  <= req_user;
            base_q <= root_base;
            lvl    <= '0;
            state  <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            ent_q <= mem_rsp_data;
            state <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (verdict != FLT_NONE) begin
            res_fault_q <= verdict;
            res_ppn_q   <= '0;
            res_lvl_q   <= lvl;
            state       <= ST_RES;
          end else if (a_clear) begin
            state <= ST_WB;
          end else if (last_lvl) begin
            res_fault_q <= FLT_NONE;
            res_ppn_q   <= child_base;
            res_lvl_q   <= lvl;
            state       <= ST_RES;
          end else begin
            base_q <= child_base;
            lvl    <= lvl + LVL_W'(1);
            state  <= ST_RD;
          end
        end
        ST_WB: begin
          if (mem_req_ready) begin
            if (last_lvl) begin
              res_fault_q <= FLT_NONE;
              res_ppn_q   <= child_base;
              res_lvl_q   <= lvl;
              state       <= ST_RES;
            end else begin
              base_q <= child_base;
              lvl    <= lvl + LVL_W'(1);
              state  <= ST_RD;
            end
          end
        end
        ST_RES: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_RD) || (state == ST_WB);
  assign mem_req_write = (state == ST_WB);
  assign mem_req_addr  = ent_addr;
  assign mem_req_wdata = (state == ST_WB) ? entry_marked : '0;
  assign res_valid     = (state == ST_RES);
  assign res_ppn       = res_ppn_q;
  assign res_fault     = res_fault_q;
  assign res_level     = res_lvl_q;

  // Accepting a request starts with a level-0 read on the next cycle.
  assert_accept_reads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req_valid && !mem_req_write && !req_ready);

  // A stalled memory request keeps every field.
  assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // A stalled result keeps every field.
  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_ppn)
      && $stable(res_fault) && $stable(res_level));

  // Every write-back marks the entry as referenced.
  assert_wb_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[PTE_A_BIT]);

  // A clean result is only ever produced at the last level.
  assert_ok_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_fault == FLT_NONE) |-> res_level == LVL_W'(LEVELS - 1));
endmodule

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [39:0] ROOT = 40'h00042;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [39:0] root_base;
  logic        req_valid, req_ready, req_write, req_user;
  logic [35:0] req_vpn;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid, res_ready;
  logic [39:0] res_ppn;
  logic [1:0]  res_fault, res_level;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwalk_top u0 (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_ppn(res_ppn), .res_fault(res_fault), .res_level(res_level)
  );

  logic [63:0] mem     [logic [51:0]];
  logic [63:0] ref_mem [logic [51:0]];

  logic        exp_we_q   [$];
  logic [51:0] exp_addr_q [$];
  logic [63:0] exp_data_q [$];
  logic [39:0] exp_ppn_q  [$];
  logic [1:0]  exp_flt_q  [$];
  logic [1:0]  exp_lvl_q  [$];

  int    vectors = 0;
  int    miscompares = 0;
  int    results_seen = 0;
  int    cyc = 0;
  int    res_hold = 0;
  int    rsp_cnt = 0;
  bit    stall_mode = 0;
  bit    busy = 0;
  bit    finished = 0;
  string cur_tag = "R7";
  logic [63:0] rsp_buf;

  function automatic void check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [63:0] rd_ref(logic [51:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 64'h0;
  endfunction

  function automatic logic [51:0] ent_at(logic [39:0] base, logic [8:0] idx);
    return {base, 12'h000} + (52'(idx) << 3);
  endfunction

  // Behavioural walk over the bench's own copy of the tables.
  function automatic void model_walk(logic [35:0] vpn, logic wr, logic usr);
    logic [39:0] base;
    logic [51:0] a;
    logic [63:0] e;
    base = ROOT;
    for (int l = 0; l < 4; l++) begin
      a = ent_at(base, vpn[(3-l)*9 +: 9]);
      e = rd_ref(a);
      exp_we_q.push_back(1'b0); exp_addr_q.push_back(a); exp_data_q.push_back(64'h0);
      if (!e[0]) begin
        exp_ppn_q.push_back('0); exp_flt_q.push_back(2'd1); exp_lvl_q.push_back(2'(l));
        return;
      end
      if ((wr && !e[1]) || (usr && !e[2])) begin
        exp_ppn_q.push_back('0); exp_flt_q.push_back(2'd2); exp_lvl_q.push_back(2'(l));
        return;
      end
      if (!e[5]) begin
        e[5] = 1'b1;
        ref_mem[a] = e;
        exp_we_q.push_back(1'b1); exp_addr_q.push_back(a); exp_data_q.push_back(e);
      end
      base = e[51:12];
    end
    exp_ppn_q.push_back(base); exp_flt_q.push_back(2'd0); exp_lvl_q.push_back(2'd3);
  endfunction

  function automatic logic [35:0] mk_vpn(int i0, int i1, int i2, int i3);
    return {9'(i0), 9'(i1), 9'(i2), 9'(i3)};
  endfunction

  // Lays out one chain of tables; masks hold one bit per level.
  task automatic build(int id, logic [35:0] vpn, logic [39:0] ppn,
                       logic [3:0] pm, logic [3:0] wm, logic [3:0] um, logic [3:0] am);
    logic [39:0] tbl, child;
    logic [51:0] a;
    logic [63:0] e;
    for (int l = 0; l < 4; l++) begin
      tbl   = (l == 0) ? ROOT : 40'h100 + 40'(id * 16 + l);
      child = (l == 3) ? ppn  : 40'h100 + 40'(id * 16 + l + 1);
      a = ent_at(tbl, vpn[(3-l)*9 +: 9]);
      e = (64'(child) << 12) | 64'(pm[l]) | (64'(wm[l]) << 1)
          | (64'(um[l]) << 2) | (64'(am[l]) << 5);
      mem[a] = e;
      ref_mem[a] = e;
    end
  endtask

  // Memory, consumer and comparison, all at the falling edge.
  logic        pm_stall, pr_stall;
  logic        sv_we;
  logic [51:0] sv_addr;
  logic [63:0] sv_wdata;
  logic [39:0] sv_ppn;
  logic [1:0]  sv_flt, sv_lvl;

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    res_ready     = 1'b0;
    pm_stall = 0; pr_stall = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || finished) continue;
      cyc++;
      mem_req_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_buf;
        end
      end
      res_ready = (res_hold == 0);
      if (res_valid && res_hold > 0) res_hold--;

      check("R1", "req_ready", 64'(req_ready), 64'(!busy));

      if (pm_stall) begin
        check("R9", "held mem valid", 64'(mem_req_valid), 64'h1);
        check("R9", "held mem addr", 64'(mem_req_addr), 64'(sv_addr));
        check("R9", "held mem dir", 64'(mem_req_write), 64'(sv_we));
        check("R9", "held mem data", mem_req_wdata, sv_wdata);
      end
      if (pr_stall) begin
        check("R8", "held result valid", 64'(res_valid), 64'h1);
        check("R8", "held ppn", 64'(res_ppn), 64'(sv_ppn));
        check("R8", "held fault", 64'(res_fault), 64'(sv_flt));
        check("R8", "held level", 64'(res_level), 64'(sv_lvl));
      end

      if (mem_req_valid && mem_req_ready) begin
        if (exp_we_q.size() == 0) begin
          check("R3", "unexpected memory request", 64'(mem_req_addr), 64'h0);
        end else begin
          check(exp_we_q[0] ? "R6" : "R2", "mem direction", 64'(mem_req_write), 64'(exp_we_q[0]));
          check(exp_we_q[0] ? "R6" : "R2", "mem address", 64'(mem_req_addr), 64'(exp_addr_q[0]));
          if (exp_we_q[0]) check("R6", "write data", mem_req_wdata, exp_data_q[0]);
          void'(exp_we_q.pop_front()); void'(exp_addr_q.pop_front()); void'(exp_data_q.pop_front());
        end
        if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
        end else begin
          rsp_buf = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
          rsp_cnt = 1 + (cyc % 3);
        end
      end

      if (req_valid && req_ready) begin
        model_walk(req_vpn, req_write, req_user);
        busy = 1;
      end

      if (res_valid && res_ready) begin
        if (exp_flt_q.size() == 0) begin
          check(cur_tag, "unexpected result", 64'(res_fault), 64'h0);
        end else begin
          check(cur_tag, "fault code", 64'(res_fault), 64'(exp_flt_q[0]));
          check(cur_tag, "level", 64'(res_level), 64'(exp_lvl_q[0]));
          check(cur_tag, "ppn", 64'(res_ppn), 64'(exp_ppn_q[0]));
          void'(exp_flt_q.pop_front()); void'(exp_lvl_q.pop_front()); void'(exp_ppn_q.pop_front());
        end
        busy = 0;
        results_seen++;
      end

      pm_stall = mem_req_valid && !mem_req_ready;
      sv_we = mem_req_write; sv_addr = mem_req_addr; sv_wdata = mem_req_wdata;
      pr_stall = res_valid && !res_ready;
      sv_ppn = res_ppn; sv_flt = res_fault; sv_lvl = res_level;
    end
  end

  task automatic walk(logic [35:0] vpn, logic wr, logic usr, string tag, int hold);
    int n;
    cur_tag  = tag;
    res_hold = hold;
    n = results_seen;
    @(posedge clk); #1;
    req_vpn = vpn; req_write = wr; req_user = usr; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (results_seen == n) @(negedge clk);
    @(negedge clk);
    check(tag, "leftover memory traffic", 64'(exp_we_q.size()), 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; root_base = ROOT;
    req_valid = 1'b0; req_vpn = '0; req_write = 1'b0; req_user = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10", "reset req_ready", 64'(req_ready), 64'h1);
    check("R10", "reset res_valid", 64'(res_valid), 64'h0);
    check("R10", "reset mem_req_valid", 64'(mem_req_valid), 64'h0);

    build(1, mk_vpn(1, 5, 7, 9), 40'hABCDE, 4'hF, 4'hF, 4'hF, 4'h0);
    walk(mk_vpn(1, 5, 7, 9), 1'b0, 1'b0, "R7", 0);   // full walk, four write-backs
    walk(mk_vpn(1, 5, 7, 9), 1'b0, 1'b0, "R6", 0);   // referenced bits now set

    build(2, mk_vpn(2, 3, 4, 5), 40'h11111, 4'b1011, 4'hF, 4'hF, 4'h0);
    walk(mk_vpn(2, 3, 4, 5), 1'b0, 1'b0, "R3", 0);   // absent at level 2

    build(3, mk_vpn(3, 0, 0, 0), 40'h22222, 4'hF, 4'b1101, 4'hF, 4'h0);
    walk(mk_vpn(3, 0, 0, 0), 1'b1, 1'b0, "R4", 0);   // write blocked at level 1
    walk(mk_vpn(3, 0, 0, 0), 1'b0, 1'b0, "R4", 0);   // read ignores the write bit

    build(4, mk_vpn(4, 511, 1, 2), 40'h33333, 4'hF, 4'hF, 4'b0111, 4'h0);
    walk(mk_vpn(4, 511, 1, 2), 1'b0, 1'b1, "R5", 5); // user blocked at level 3, held result
    walk(mk_vpn(4, 511, 1, 2), 1'b0, 1'b0, "R8", 4); // supervisor passes, held result

    build(5, mk_vpn(5, 6, 6, 6), 40'h44444, 4'b1101, 4'hF, 4'b1101, 4'h0);
    walk(mk_vpn(5, 6, 6, 6), 1'b0, 1'b1, "R5", 0);   // absent outranks forbidden

    stall_mode = 1;
    build(6, mk_vpn(6, 511, 511, 511), 40'hFFFFFFFFFF, 4'hF, 4'hF, 4'hF, 4'b0101);
    walk(mk_vpn(6, 511, 511, 511), 1'b1, 1'b1, "R9", 3);
    build(7, mk_vpn(511, 0, 511, 0), 40'h55555, 4'hF, 4'hF, 4'hF, 4'hF);
    walk(mk_vpn(511, 0, 511, 0), 1'b1, 1'b0, "R2", 0);
    stall_mode = 0;

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule